// File: doc/BRIEF.md
# Buffered 16-bit Compare Channel

This block is one compare channel that sits beside a 16-bit timer counter. Software loads a 16-bit compare value over an 8-bit data bus. A high-byte holding register makes that load atomic. The channel compares the value it holds with the live timer count. On equality it raises a match signal. One timer tick later it sets a sticky event flag, and that flag can drive an interrupt request.

The channel decodes the counter's 4-bit waveform mode code. In the pulse-width modes, a software write lands in a shadow buffer. The value the comparator uses is loaded from that buffer only at a count extreme: TOP for some codes and BOTTOM for others. This keeps every pulse in a period the same length. In the plain counting mode and the clear-on-match modes, a write takes effect at once.

The compare value in use is exported, so the counter can use it as its TOP value. The counter raises the `at_top` and `at_bottom` hints that tell the channel where the count is.

Top module: `ocmp16_channel`

## Requirements
- R1: After a synchronous active-low reset, the following all read zero: the value in use, the shadow buffer, the high-byte holding register and the event flag.
- R2: `match` is high in every cycle in which `count` equals `active_val`, and low otherwise. There is no register delay.
- R3: On a clock edge where `tick` is 1 and `match` is 1, `flag` becomes 1, so it is seen in the following cycle. If a clear request arrives on the same edge, the set wins.
- R4: `irq` is 1 exactly when `flag` is 1 and `irq_en` is 1.
- R5: `flag` clears on an edge with `irq_ack` = 1, or on an edge with `flag_wr` = 1 and `bus_wdata[0]` = 1. A `flag_wr` with `bus_wdata[0]` = 0 leaves the flag unchanged.
- R6: A `wr_hi` write stores `bus_wdata` only in the holding register. It changes neither `active_val` nor the readback. A following `wr_lo` write commits `{holding, bus_wdata}` as one 16-bit value on a single edge.
- R7: Mode codes 0, 4, 12 and 13 are direct modes. In these modes a `wr_lo` write updates `active_val` on the same edge, and it also updates the shadow buffer.
- R8: Mode codes 5, 6, 7, 8, 9, 14 and 15 are BOTTOM-update modes. In these modes a write changes only the buffer. `active_val` takes the buffer value on an edge with `tick` = 1 and `at_bottom` = 1. `at_top` has no effect.
- R9: Mode codes 1, 2, 3, 10 and 11 are TOP-update modes. In these modes `active_val` takes the buffer value on an edge with `tick` = 1 and `at_top` = 1. `at_bottom` has no effect.
- R10: With `rd_hi_sel` = 0, `rd_data` shows the buffer's low byte. A `rd_lo` pulse copies the buffer's high byte into the holding register. With `rd_hi_sel` = 1, `rd_data` shows the holding register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Timer clock enable; the count advances on edges where this is 1 |
| count | input | 16 | Live timer count |
| at_top | input | 1 | Counter reports that the count is at TOP |
| at_bottom | input | 1 | Counter reports that the count is at BOTTOM |
| mode | input | 4 | Waveform mode code |
| bus_wdata | input | 8 | Write data byte |
| wr_hi | input | 1 | High-byte write strobe |
| wr_lo | input | 1 | Low-byte write strobe (commits the 16-bit value) |
| rd_lo | input | 1 | Low-byte read strobe (latches the high byte for a later read) |
| rd_hi_sel | input | 1 | Selects the holding register onto `rd_data` |
| flag_wr | input | 1 | Flag write strobe; a 1 in bit 0 clears the flag |
| irq_ack | input | 1 | Interrupt acknowledge; clears the flag |
| irq_en | input | 1 | Interrupt enable |
| rd_data | output | 8 | Read data byte |
| match | output | 1 | Count equals the value in use |
| flag | output | 1 | Sticky compare event flag |
| irq | output | 1 | Interrupt request |
| active_val | output | 16 | Compare value in use, offered to the counter as TOP |

## Verification
A direct-mode random run mixes four things:
- counts that equal the value in use, miss it by one, or sit far from it;
- random byte writes;
- flag clears and acknowledges;
- interrupt enable toggling.

This tells a wrong comparator or a wrong flag timing apart from a wrong clear path. Directed cases cover the rest:
- A write in the middle of a period in one BOTTOM-update code and one TOP-update code. Each is followed by the wrong extreme and then the right one. This separates early loading, and loading on the wrong extreme, from correct double buffering.
- A lone high-byte write, set-against-clear on the same edge, and a zero-bit flag write. These show atomicity, priority and the ignored-clear case at the ports.

// File: rtl/ocmp_pkg.sv
`timescale 1ns/1ps
// Package: shared types and mode decode for the compare channel.
// Assumes a 4-bit mode code; the decode below is the single source of truth.
package ocmp_pkg;

    typedef enum logic [1:0] {
        UPD_DIRECT = 2'd0,
        UPD_TOP    = 2'd1,
        UPD_BOTTOM = 2'd2
    } upd_kind_t;

    // Map a mode code to the moment at which the compare value may change.
    function automatic upd_kind_t mode_to_upd(input logic [3:0] code);
        upd_kind_t k;
        case (code)
            4'd0, 4'd4, 4'd12, 4'd13:                  k = UPD_DIRECT;
            4'd1, 4'd2, 4'd3, 4'd10, 4'd11:            k = UPD_TOP;
            default:                                   k = UPD_BOTTOM;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/ocmp_mode_decode.sv
`timescale 1ns/1ps
// Mode decode: turns the waveform mode code into two control levels.
// Assumes the mode input is stable or changes only between periods.
module ocmp_mode_decode (
    input  logic [3:0] mode,
    output logic       is_buffered,
    output logic       upd_at_top
);
    import ocmp_pkg::*;

    upd_kind_t kind;

    // Classify the current code.
    always_comb begin
        kind        = mode_to_upd(mode);
        is_buffered = (kind != UPD_DIRECT);
        upd_at_top  = (kind == UPD_TOP);
    end
endmodule

// File: rtl/ocmp_bus_port.sv
`timescale 1ns/1ps
// Bus port: the byte-wide access path with the high-byte holding register
// and the shadow buffer. A high write only fills the holding register; a
// low write presents the full word for commit. Assumes one strobe per cycle.
module ocmp_bus_port #(
    parameter int BUS_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [BUS_W-1:0]   bus_wdata,
    input  logic               wr_hi,
    input  logic               wr_lo,
    input  logic               rd_lo,
    input  logic               rd_hi_sel,
    output logic [2*BUS_W-1:0] buf_val,
    output logic [2*BUS_W-1:0] commit_val,
    output logic               commit,
    output logic [BUS_W-1:0]   rd_data
);
    localparam int WORD_W = 2 * BUS_W;

    logic [BUS_W-1:0]  hold_q;
    logic [WORD_W-1:0] shadow_q;

    // Word formed by the holding byte and the incoming low byte.
    always_comb begin
        commit_val = {hold_q, bus_wdata};
        commit     = wr_lo;
        buf_val    = shadow_q;
        rd_data    = rd_hi_sel ? hold_q : shadow_q[BUS_W-1:0];
    end

    // Holding register: written by a high write, or loaded by a low read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hold_q <= '0;
        else if (wr_hi)
            hold_q <= bus_wdata;
        else if (rd_lo)
            hold_q <= shadow_q[WORD_W-1:BUS_W];
    end

    // Shadow buffer: takes the whole word on every low write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            shadow_q <= '0;
        else if (wr_lo)
            shadow_q <= commit_val;
    end
endmodule

// File: rtl/ocmp_active_reg.sv
`timescale 1ns/1ps
// Active compare register: the value used by the comparator and offered
// as TOP. Direct modes load it on commit; buffered modes copy the shadow
// buffer on a tick at the chosen count extreme. Assumes at_top/at_bottom
// describe the count present during the tick cycle.
module ocmp_active_reg #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             is_buffered,
    input  logic             upd_at_top,
    input  logic             tick,
    input  logic             at_top,
    input  logic             at_bottom,
    input  logic             commit,
    input  logic [CNT_W-1:0] commit_val,
    input  logic [CNT_W-1:0] buf_val,
    output logic [CNT_W-1:0] active_val
);
    logic             extreme_hit;
    logic [CNT_W-1:0] active_q;

    // Pick the extreme that releases the buffer in the current mode.
    always_comb begin
        extreme_hit = tick && (upd_at_top ? at_top : at_bottom);
        active_val  = active_q;
    end

    // Load the value in use from the bus or from the buffer.
    always_ff @(posedge clk) begin
        if (!rst_n)
            active_q <= '0;
        else if (!is_buffered && commit)
            active_q <= commit_val;
        else if (is_buffered && extreme_hit)
            active_q <= buf_val;
    end
endmodule

// File: rtl/ocmp_flag_irq.sv
`timescale 1ns/1ps
// Event flag and interrupt: the flag sets on a tick that sees a match and
// clears by acknowledge or by a write of one to bit 0; setting wins.
module ocmp_flag_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic match,
    input  logic irq_ack,
    input  logic flag_wr,
    input  logic clr_bit,
    input  logic irq_en,
    output logic flag,
    output logic irq
);
    logic flag_q;
    logic set_req;
    logic clr_req;

    // Form the set and clear requests.
    always_comb begin
        set_req = tick && match;
        clr_req = irq_ack || (flag_wr && clr_bit);
        flag    = flag_q;
        irq     = flag_q && irq_en;
    end

    // Sticky flag with set priority.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_q <= 1'b0;
        else if (set_req)
            flag_q <= 1'b1;
        else if (clr_req)
            flag_q <= 1'b0;
    end
endmodule

// File: rtl/ocmp16_channel.sv
`timescale 1ns/1ps
// Top: one compare channel for a timer counter. Ties the bus port, mode
// decode, active register, equality comparator and flag logic together.
// Assumes CNT_W is twice the bus width and the counter drives the hints.
module ocmp16_channel #(
    parameter int CNT_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic [CNT_W-1:0]   count,
    input  logic               at_top,
    input  logic               at_bottom,
    input  logic [3:0]         mode,
    input  logic [CNT_W/2-1:0] bus_wdata,
    input  logic               wr_hi,
    input  logic               wr_lo,
    input  logic               rd_lo,
    input  logic               rd_hi_sel,
    input  logic               flag_wr,
    input  logic               irq_ack,
    input  logic               irq_en,
    output logic [CNT_W/2-1:0] rd_data,
    output logic               match,
    output logic               flag,
    output logic               irq,
    output logic [CNT_W-1:0]   active_val
);
    localparam int BUS_W = CNT_W / 2;

    logic             is_buffered;
    logic             upd_at_top;
    logic [CNT_W-1:0] buf_val;
    logic [CNT_W-1:0] commit_val;
    logic             commit;

    ocmp_mode_decode u_dec (
        .mode        (mode),
        .is_buffered (is_buffered),
        .upd_at_top  (upd_at_top)
    );

    ocmp_bus_port #(.BUS_W(BUS_W)) u_port (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wdata  (bus_wdata),
        .wr_hi      (wr_hi),
        .wr_lo      (wr_lo),
        .rd_lo      (rd_lo),
        .rd_hi_sel  (rd_hi_sel),
        .buf_val    (buf_val),
        .commit_val (commit_val),
        .commit     (commit),
        .rd_data    (rd_data)
    );

    ocmp_active_reg #(.CNT_W(CNT_W)) u_act (
        .clk         (clk),
        .rst_n       (rst_n),
        .is_buffered (is_buffered),
        .upd_at_top  (upd_at_top),
        .tick        (tick),
        .at_top      (at_top),
        .at_bottom   (at_bottom),
        .commit      (commit),
        .commit_val  (commit_val),
        .buf_val     (buf_val),
        .active_val  (active_val)
    );

    // Continuous equality comparison against the live count.
    always_comb match = (count == active_val);

    ocmp_flag_irq u_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .match   (match),
        .irq_ack (irq_ack),
        .flag_wr (flag_wr),
        .clr_bit (bus_wdata[0]),
        .irq_en  (irq_en),
        .flag    (flag),
        .irq     (irq)
    );
endmodule

// File: rtl/ocmp16_checker.sv
`timescale 1ns/1ps
// Checker: temporal properties of the compare channel, seen at its ports.
module ocmp16_checker #(
    parameter int CNT_W = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               tick,
    input logic               at_top,
    input logic               at_bottom,
    input logic [3:0]         mode,
    input logic [CNT_W/2-1:0] bus_wdata,
    input logic               wr_hi,
    input logic               wr_lo,
    input logic               flag_wr,
    input logic               irq_ack,
    input logic               irq_en,
    input logic               match,
    input logic               flag,
    input logic               irq,
    input logic [CNT_W-1:0]   active_val
);
    import ocmp_pkg::*;

    logic buffered;
    logic any_edge;
    always_comb begin
        buffered = (mode_to_upd(mode) != UPD_DIRECT);
        any_edge = tick && (at_top || at_bottom);
    end

    a_r3_flag_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && match) |=> flag);

    a_r4_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (flag && irq_en));

    a_r5_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && !(tick && match)) |=> !flag);

    a_r5_zero_write_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && flag_wr && !bus_wdata[0] && !irq_ack) |=> flag);

    a_r6_hi_write_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hi && !wr_lo && !(buffered && any_edge)) |=> $stable(active_val));

    a_r7_direct_low_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lo && !buffered) |=> (active_val[CNT_W/2-1:0] == $past(bus_wdata)));

    a_r8_buffered_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (buffered && !any_edge) |=> $stable(active_val));
endmodule

bind ocmp16_channel ocmp16_checker #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .at_top     (at_top),
    .at_bottom  (at_bottom),
    .mode       (mode),
    .bus_wdata  (bus_wdata),
    .wr_hi      (wr_hi),
    .wr_lo      (wr_lo),
    .flag_wr    (flag_wr),
    .irq_ack    (irq_ack),
    .irq_en     (irq_en),
    .match      (match),
    .flag       (flag),
    .irq        (irq),
    .active_val (active_val)
);

// File: tb/sim_ocmp16_channel.sv
`timescale 1ns/1ps
module sim_ocmp16_channel;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        tick, at_top, at_bottom;
    logic [15:0] count;
    logic [3:0]  mode;
    logic [7:0]  bus_wdata;
    logic        wr_hi, wr_lo, rd_lo, rd_hi_sel, flag_wr, irq_ack, irq_en;
    logic [7:0]  rd_data;
    logic        match, flag, irq;
    logic [15:0] active_val;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    ocmp16_channel u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .count(count),
        .at_top(at_top), .at_bottom(at_bottom), .mode(mode),
        .bus_wdata(bus_wdata), .wr_hi(wr_hi), .wr_lo(wr_lo), .rd_lo(rd_lo),
        .rd_hi_sel(rd_hi_sel), .flag_wr(flag_wr), .irq_ack(irq_ack),
        .irq_en(irq_en), .rd_data(rd_data), .match(match), .flag(flag),
        .irq(irq), .active_val(active_val)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic exp_match(input logic [15:0] c, input logic [15:0] a);
        return c == a;
    endfunction

    task automatic idle();
        tick = 0; at_top = 0; at_bottom = 0; wr_hi = 0; wr_lo = 0;
        rd_lo = 0; flag_wr = 0; irq_ack = 0;
    endtask

    // one edge: inputs already set at negedge; return at next negedge
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        idle();
    endtask

    task automatic write16(input logic [15:0] v);
        bus_wdata = v[15:8]; wr_hi = 1; step();
        bus_wdata = v[7:0];  wr_lo = 1; step();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] e_act;
        logic [7:0]  e_hold;
        logic        e_flag;
        void'($urandom(32'h5eed_0c01));
        idle(); rst_n = 0; count = 16'h7777; mode = 4'd0;
        bus_wdata = 0; rd_hi_sel = 0; irq_en = 0;
        @(negedge clk); step();
        rst_n = 1;
        // R1 reset state
        chk("R1 active", active_val, 16'h0000);
        chk("R1 flag", flag, 0);
        chk("R1 buffer low", rd_data, 8'h00);
        rd_hi_sel = 1; #1 chk("R1 holding", rd_data, 8'h00); rd_hi_sel = 0;

        // R7 direct write, R6 high byte alone
        write16(16'h1234);
        chk("R7 direct commit", active_val, 16'h1234);
        bus_wdata = 8'hAB; wr_hi = 1; step();
        chk("R6 high only keeps active", active_val, 16'h1234);
        chk("R6 high only keeps readback", rd_data, 8'h34);
        bus_wdata = 8'hCD; wr_lo = 1; step();
        chk("R6 low commits word", active_val, 16'hABCD);

        // R10 readback
        chk("R10 low byte", rd_data, 8'hCD);
        rd_lo = 1; step();
        rd_hi_sel = 1; #1 chk("R10 high via holding", rd_data, 8'hAB); rd_hi_sel = 0;

        // R2/R3/R4 flag timing
        irq_en = 1; count = 16'hABCD; #1 chk("R2 match comb", match, 1);
        chk("R3 flag not same cycle", flag, 0);
        tick = 1; step();
        chk("R3 flag after tick", flag, 1);
        chk("R4 irq", irq, 1);
        irq_en = 0; #1 chk("R4 irq masked", irq, 0); irq_en = 1;
        count = 16'hABCE; #1 chk("R2 no match", match, 0);
        flag_wr = 1; bus_wdata = 8'hFE; step();
        chk("R5 zero bit ignored", flag, 1);
        flag_wr = 1; bus_wdata = 8'h01; step();
        chk("R5 write one clears", flag, 0);
        count = 16'hABCD; tick = 1; irq_ack = 1; step();
        chk("R3 set beats clear", flag, 1);
        count = 16'h0000; irq_ack = 1; step();
        chk("R5 ack clears", flag, 0);

        // R8 bottom-update code 14
        mode = 4'd14; write16(16'h0500);
        chk("R8 mid-period write held", active_val, 16'hABCD);
        count = 16'h0500; tick = 1; #1 chk("R8 no match at new value", match, 0); step();
        chk("R8 no flag from pending", flag, 0);
        tick = 1; at_top = 1; step();
        chk("R8 top ignored", active_val, 16'hABCD);
        tick = 1; at_bottom = 1; step();
        chk("R8 bottom loads", active_val, 16'h0500);

        // R9 top-update code 10
        mode = 4'd10; write16(16'h0777);
        chk("R9 mid-period write held", active_val, 16'h0500);
        tick = 1; at_bottom = 1; step();
        chk("R9 bottom ignored", active_val, 16'h0500);
        at_top = 1; step();
        chk("R9 top without tick ignored", active_val, 16'h0500);
        tick = 1; at_top = 1; step();
        chk("R9 top loads", active_val, 16'h0777);

        // Random direct-mode run
        mode = 4'd0; irq_ack = 1; step();
        e_act = 16'h0777; e_hold = 8'h07; e_flag = 0;
        for (int i = 0; i < 3000; i++) begin
            int op;
            logic hit;
            chk("R2 random match", match, exp_match(count, e_act));
            chk("R3 random flag", flag, e_flag);
            chk("R4 random irq", irq, e_flag && irq_en);
            chk("R7 random active", active_val, e_act);
            op = $urandom_range(0, 5);
            tick = $urandom_range(0, 1);
            irq_en = $urandom_range(0, 1);
            case ($urandom_range(0, 2))
                0: count = e_act;
                1: count = e_act + 16'd1;
                default: count = 16'($urandom);
            endcase
            bus_wdata = 8'($urandom);
            hit = tick && (count == e_act);
            case (op)
                1: begin wr_hi = 1; e_hold = bus_wdata; end
                2: begin wr_lo = 1; end
                3: flag_wr = 1;
                4: irq_ack = 1;
                default: ;
            endcase
            if (hit) e_flag = 1;
            else if (irq_ack || (flag_wr && bus_wdata[0])) e_flag = 0;
            if (wr_lo) e_act = {e_hold, bus_wdata};
            step();
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule